// File: doc/BRIEF.md
# Accelerator Local Bus Interconnect

This block sits between a stack-based processor core and a group of up to thirty-two hardware accelerators on a short, private local bus. The core issues three micro-operation strobes, each carrying its top-of-stack word. The first strobe latches that word as the accelerator address. The second sends the word to the chosen accelerator. The third fetches one word back from it.

The latched address is driven onto the bus continuously. Each accelerator is chosen by one address bit: bit k names accelerator k, and that bit is qualified by the global select. Every transfer takes exactly one clock cycle. There are no wait states, no acknowledge and no stall towards the core.

Read data is captured in a register and presented to the core on the cycle after the load strobe. If the address does not name exactly one accelerator, the access is dropped and a load returns zero.

Top module: `accel_lbus_ctrl`

## Requirements
- R1: While reset is high, and on the first edge after it, the latched address and the core read word are zero. With no strobe active, the global select is low and read-not-write is high.
- R2: A select-address strobe loads the top-of-stack word into the address register, which appears on the bus address on the following cycle. Without the strobe, the bus address holds its value.
- R3: During a store strobe with a valid address, the global select is 1, read-not-write is 0 and the bus write data equals the top-of-stack word. The per-accelerator select vector equals the low address bits, so exactly one bit is set and bit k selects accelerator k.
- R4: During a load strobe with a valid address, the global select is 1, read-not-write is 1 and the per-accelerator select is set as in R3. On the next cycle the core read word equals the read data of the selected accelerator. The read word holds until the next load strobe.
- R5: With neither a store strobe nor a load strobe, the global select is 0, read-not-write is 1 and all per-accelerator selects are 0.
- R6: An address is invalid when its low accelerator bits are all zero or have more than one bit set. An access to an invalid address raises no select (global or per-accelerator), and a load from it makes the read word zero on the next cycle.
- R7: When store and load strobes are active together, the store is performed and the load is dropped: read-not-write is 0 and the read word keeps its previous value.
- R8: An access issued in the same cycle as a select-address strobe uses the previously latched address. The new address takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_setaddr | input | 1 | Select-address strobe |
| op_store | input | 1 | Store-to-accelerator strobe |
| op_load | input | 1 | Load-from-accelerator strobe |
| tos | input | 32 | Top-of-stack word from the core |
| rd_word | output | 32 | Registered read word to the core |
| bus_addr | output | 32 | Latched accelerator address |
| bus_wdata | output | 32 | Write data to the accelerators |
| bus_sel | output | 1 | Global select |
| bus_rnw | output | 1 | Read-not-write (1 = read) |
| acc_sel | output | 32 | One select per accelerator |
| acc_rdata | input | 1024 | Read words from all accelerators; accelerator k on bits [32k+31:32k] |

## Verification
The address decode is driven with one-hot addresses at both end positions (accelerator 0 and accelerator 31) and in between, with an all-zero address and with two-bit and random multi-bit patterns. These patterns separate a correct one-hot check from a simple "any bit set" test. Strobes are tried alone and in combination. Store together with load shows store priority. Select-address together with an access shows that the old address is used. A run of idle cycles shows that the read word is held. Accelerator read words are redrawn every cycle, so a mux that picks the wrong lane, or samples in the wrong cycle, returns a visibly different word.

// File: rtl/alb_pkg.sv
package alb_pkg;

    localparam int unsigned ALB_ADDR_W = 32;
    localparam int unsigned ALB_DATA_W = 32;
    localparam int unsigned ALB_N_ACC  = 32;

    typedef struct packed {
        logic setaddr;
        logic store;
        logic load;
    } alb_op_t;

    typedef struct packed {
        logic store;
        logic load;
        logic any;
    } alb_fire_t;

    // Store has priority over a simultaneous load.
    function automatic alb_fire_t resolve_op(input alb_op_t op);
        alb_fire_t f;
        f.store = op.store;
        f.load  = op.load & ~op.store;
        f.any   = op.store | op.load;
        return f;
    endfunction

endpackage

// File: rtl/alb_addr_reg.sv
module alb_addr_reg #(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] din,
    output logic [ADDR_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= din;
        end
    end

    assert_addr_latch_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> (q == $past(din)));

    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q));

endmodule

// File: rtl/alb_decode.sv
module alb_decode #(
    parameter int unsigned N_ACC = 32
) (
    input  logic [N_ACC-1:0] addr_bits,
    input  logic             en,
    output logic [N_ACC-1:0] sel,
    output logic             hit
);

    logic [N_ACC-1:0] seen;
    logic [N_ACC-1:0] dup;

    assign seen[0] = addr_bits[0];
    assign dup[0]  = 1'b0;

    genvar i;
    generate
        for (i = 1; i < N_ACC; i++) begin : g_scan
            assign seen[i] = seen[i-1] | addr_bits[i];
            assign dup[i]  = dup[i-1] | (seen[i-1] & addr_bits[i]);
        end
    endgenerate

    assign hit = seen[N_ACC-1] & ~dup[N_ACC-1];
    assign sel = (en && hit) ? addr_bits : '0;

endmodule

// File: rtl/alb_rdmux.sv
module alb_rdmux #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned N_ACC  = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ld_en,
    input  logic                    hit,
    input  logic [N_ACC-1:0]        sel,
    input  logic [N_ACC*DATA_W-1:0] acc_rdata,
    output logic [DATA_W-1:0]       rd_q
);

    logic [DATA_W-1:0] masked [N_ACC];
    logic [DATA_W-1:0] chain  [N_ACC];

    genvar k;
    generate
        for (k = 0; k < N_ACC; k++) begin : g_lane
            assign masked[k] = acc_rdata[k*DATA_W +: DATA_W] & {DATA_W{sel[k]}};
            if (k == 0) begin : g_first
                assign chain[k] = masked[k];
            end else begin : g_rest
                assign chain[k] = chain[k-1] | masked[k];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (ld_en) begin
            rd_q <= chain[N_ACC-1];
        end
    end

    assert_bad_load_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (ld_en && !hit) |=> (rd_q == '0));

    assert_read_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !ld_en |=> $stable(rd_q));

endmodule

// File: rtl/accel_lbus_ctrl.sv
module accel_lbus_ctrl
    import alb_pkg::*;
#(
    parameter int unsigned ADDR_W = ALB_ADDR_W,
    parameter int unsigned DATA_W = ALB_DATA_W,
    parameter int unsigned N_ACC  = ALB_N_ACC
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    op_setaddr,
    input  logic                    op_store,
    input  logic                    op_load,
    input  logic [DATA_W-1:0]       tos,
    output logic [DATA_W-1:0]       rd_word,
    output logic [ADDR_W-1:0]       bus_addr,
    output logic [DATA_W-1:0]       bus_wdata,
    output logic                    bus_sel,
    output logic                    bus_rnw,
    output logic [N_ACC-1:0]        acc_sel,
    input  logic [N_ACC*DATA_W-1:0] acc_rdata
);

    localparam int unsigned SEL_W = N_ACC;

    alb_op_t           op;
    alb_fire_t         fire;
    logic [ADDR_W-1:0] addr_q;
    logic              hit;

    assign op   = '{setaddr: op_setaddr, store: op_store, load: op_load};
    assign fire = resolve_op(op);

    alb_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
        .clk  (clk),
        .rst  (rst),
        .load (op.setaddr),
        .din  (tos[ADDR_W-1:0]),
        .q    (addr_q)
    );

    alb_decode #(.N_ACC(SEL_W)) u_dec (
        .addr_bits (addr_q[SEL_W-1:0]),
        .en        (fire.any),
        .sel       (acc_sel),
        .hit       (hit)
    );

    alb_rdmux #(.DATA_W(DATA_W), .N_ACC(SEL_W)) u_rd (
        .clk       (clk),
        .rst       (rst),
        .ld_en     (fire.load),
        .hit       (hit),
        .sel       (acc_sel),
        .acc_rdata (acc_rdata),
        .rd_q      (rd_word)
    );

    assign bus_addr  = addr_q;
    assign bus_wdata = tos;
    assign bus_sel   = fire.any & hit;
    assign bus_rnw   = ~fire.store;

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (bus_addr == '0 && rd_word == '0));

    assert_sel_onehot_R3: assert property (@(posedge clk) disable iff (rst)
        bus_sel |-> $onehot(acc_sel));

    assert_no_sel_leak_R6: assert property (@(posedge clk) disable iff (rst)
        !bus_sel |-> (acc_sel == '0));

    assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (!op_store && !op_load) |-> (!bus_sel && bus_rnw));

    assert_store_wins_R7: assert property (@(posedge clk) disable iff (rst)
        (op_store && op_load) |=> $stable(rd_word));

endmodule

// File: tb/sim_accel_lbus_ctrl.sv
`timescale 1ns/1ps
module sim_accel_lbus_ctrl;

    localparam int NA = 32;
    localparam int DW = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              op_setaddr = 1'b0;
    logic              op_store = 1'b0;
    logic              op_load = 1'b0;
    logic [DW-1:0]     tos = '0;
    logic [DW-1:0]     rd_word;
    logic [DW-1:0]     bus_addr;
    logic [DW-1:0]     bus_wdata;
    logic              bus_sel;
    logic              bus_rnw;
    logic [NA-1:0]     acc_sel;
    logic [NA*DW-1:0]  acc_flat;
    logic [DW-1:0]     acc_mem [NA];

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [DW-1:0] addr_m = '0;
    logic [DW-1:0] rd_m   = '0;

    always #2 clk = ~clk;

    always_comb begin
        for (int k = 0; k < NA; k++) acc_flat[k*DW +: DW] = acc_mem[k];
    end

    accel_lbus_ctrl u0 (
        .clk(clk), .rst(rst), .op_setaddr(op_setaddr), .op_store(op_store),
        .op_load(op_load), .tos(tos), .rd_word(rd_word), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_sel(bus_sel), .bus_rnw(bus_rnw),
        .acc_sel(acc_sel), .acc_rdata(acc_flat)
    );

    function automatic bit addr_ok(input logic [DW-1:0] a);
        return $countones(a[NA-1:0]) == 1;
    endfunction

    function automatic int lane_of(input logic [DW-1:0] a);
        for (int k = 0; k < NA; k++) if (a[k]) return k;
        return 0;
    endfunction

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Starts just after a falling edge; ends at the next falling edge.
    task automatic step(input logic s, input logic st, input logic ld, input logic [DW-1:0] t);
        logic ldf;
        logic en;
        logic ok;
        op_setaddr = s; op_store = st; op_load = ld; tos = t;
        for (int k = 0; k < NA; k++) acc_mem[k] = $urandom;
        #1;
        ldf = ld & ~st;
        en  = st | ld;
        ok  = addr_ok(addr_m);
        if (!en) begin
            chk("R5 sel", {31'b0, bus_sel}, 32'd0);
            chk("R5 rnw", {31'b0, bus_rnw}, 32'd1);
            chk("R5 acc_sel", acc_sel, 32'd0);
        end else if (!ok) begin
            chk("R6 sel", {31'b0, bus_sel}, 32'd0);
            chk("R6 acc_sel", acc_sel, 32'd0);
        end else begin
            chk(st ? "R3 sel" : "R4 sel", {31'b0, bus_sel}, 32'd1);
            chk(st ? "R7 rnw" : "R4 rnw", {31'b0, bus_rnw}, {31'b0, ~st});
            chk(st ? "R3 acc_sel" : "R4 acc_sel", acc_sel, addr_m[NA-1:0]);
        end
        if (st) chk("R3 wdata", bus_wdata, t);
        @(posedge clk);
        if (ldf) rd_m = ok ? acc_mem[lane_of(addr_m)] : '0;
        if (s) addr_m = t;
        @(negedge clk);
        chk("R2 addr", bus_addr, addr_m);
        chk(ldf ? (ok ? "R4 rd" : "R6 rd") : (st && ld ? "R7 rd" : "R4 hold"), rd_word, rd_m);
        op_setaddr = 0; op_store = 0; op_load = 0;
    endtask

    function automatic logic [DW-1:0] rand_addr();
        int r;
        logic [DW-1:0] a;
        r = $urandom % 8;
        if (r < 5) a = 32'd1 << ($urandom % NA);
        else if (r == 5) a = '0;
        else if (r == 6) a = (32'd1 << ($urandom % NA)) | (32'd1 << (($urandom % (NA-1)) + 1)) | 32'd1;
        else a = $urandom;
        return a;
    endfunction

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [DW-1:0] held;
        void'($urandom(32'd20240611));
        for (int k = 0; k < NA; k++) acc_mem[k] = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1 addr", bus_addr, 32'd0);
        chk("R1 rd", rd_word, 32'd0);
        chk("R1 sel", {31'b0, bus_sel}, 32'd0);
        chk("R1 rnw", {31'b0, bus_rnw}, 32'd1);

        // directed: lane 5, store then load
        step(1, 0, 0, 32'h0000_0020);
        step(0, 1, 0, 32'hDEAD_BEEF);
        step(0, 0, 1, 32'h0);
        // boundary lanes 0 and 31
        step(1, 0, 0, 32'h0000_0001);
        step(0, 0, 1, 32'h0);
        step(1, 0, 0, 32'h8000_0000);
        step(0, 0, 1, 32'h0);
        held = rd_word;
        // idle holds read word
        step(0, 0, 0, 32'h1234_5678);
        step(0, 0, 0, 32'h0);
        chk("R4 hold idle", rd_word, held);
        // R8: new address with load in same cycle uses lane 31
        step(1, 0, 1, 32'h0000_0004);
        chk("R8 old addr used", bus_addr, 32'h0000_0004);
        // R7: store and load together
        held = rd_word;
        step(0, 1, 1, 32'hCAFE_F00D);
        chk("R7 rd kept", rd_word, held);
        // R6: zero address and two-bit address
        step(1, 0, 0, 32'h0);
        step(0, 0, 1, 32'h0);
        chk("R6 zero addr rd", rd_word, 32'd0);
        step(1, 0, 0, 32'h0000_0003);
        step(0, 1, 0, 32'h5555_AAAA);
        step(0, 0, 1, 32'h0);
        chk("R6 two-bit rd", rd_word, 32'd0);

        for (int n = 0; n < 3000; n++) begin
            int r;
            r = $urandom % 10;
            if (r < 3) step(1, $urandom % 4 == 0, $urandom % 4 == 0, rand_addr());
            else step(0, $urandom % 2, $urandom % 2, $urandom);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule